// File: doc/BRIEF.md
# Overlapping-Window Register File

This block is the integer register storage of a processor core that gives each procedure call its own set of registers without copying anything to memory. The datapath always addresses 32 logical registers with 5-bit indices. Eight of them are global and are the same physical storage whatever window is current. The other 24 are seen through a window that slides over a circular physical array, and a window pointer input chooses the window.

Adjacent windows overlap. The eight registers a caller writes its call arguments into are the same physical entries the callee reads as its incoming arguments once the pointer has moved by one. Each window adds 16 entries that belong to it alone, so `NWINDOWS` windows need `16 x NWINDOWS` windowed entries plus the globals. The block does no pointer arithmetic and no trap detection. It translates three logical indices (two reads, one write) to physical entries and stores the data.

Top module: `wreg_file`

## Requirements
- R1: Logical registers 0 to 7 are globals. Each maps to one fixed physical entry, and the window pointer has no effect on it. A value written to global g is read back from g under every pointer value.
- R2: Logical registers 8 to 15 are outs, 16 to 23 are locals and 24 to 31 are ins. Index r in 8 to 31 maps to windowed entry ((r - 8) + 16 x ptr) mod (16 x NWINDOWS). Two windows that are not neighbours share no windowed entry, so a register written in one window reads as zero in the other until it is written there.
- R3: In register 24+k of window w is the same entry as out register 8+k of window (w+1) mod NWINDOWS, for k in 0 to 7. This includes the wrap from window NWINDOWS-1 to window 0.
- R4: Local registers (16 to 23) are private to their window. A local written in window w reads as zero in windows w-1 and w+1.
- R5: While reset is asserted every entry clears to zero, and after reset every read returns zero until that entry is written.
- R6: While the write enable is low the write index and write data have no effect on any entry.
- R7: Both reads are combinational. A read whose physical entry matches an enabled write in the same cycle returns the write data in that cycle, and from the next edge on it returns the same value from storage.
- R8: The two read ports work independently. In one cycle they can return different entries of the same window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes occur on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset; clears all entries |
| win_ptr | input | clog2(NWINDOWS) | Current window, 0 to NWINDOWS-1 |
| rd_a_idx | input | 5 | Logical index of read port A |
| rd_a_data | output | DW | Data of read port A |
| rd_b_idx | input | 5 | Logical index of read port B |
| rd_b_data | output | DW | Data of read port B |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 5 | Logical index of the write port |
| wr_data | input | DW | Write data |

## Verification
The hardest case to reach from the ports is the aliasing across the wrap, where the ins of the last window must land on the outs of window 0. Only a write under one pointer value followed by a read under a different pointer value can show it. The stimulus table therefore writes under one pointer and reads back under the neighbouring pointer, and it also reads the same logical register under other pointers, where zero is expected. Forwarding is reached by putting a read index on the entry that an enabled write targets in the same cycle. The read is then held steady across the edge so that the forwarded value and the stored value are seen one after the other.

// File: rtl/wrf_pkg.sv
package wrf_pkg;

  localparam int GLOBALS    = 8;
  localparam int WIN_STRIDE = 16;
  localparam int LIDX_W     = 5;

  typedef enum logic [1:0] {
    GRP_GLOBAL = 2'd0,
    GRP_OUT    = 2'd1,
    GRP_LOCAL  = 2'd2,
    GRP_IN     = 2'd3
  } reg_group_e;

  // Register group of a logical index
  function automatic reg_group_e group_of(input int lidx);
    if (lidx < 8)       return GRP_GLOBAL;
    else if (lidx < 16) return GRP_OUT;
    else if (lidx < 24) return GRP_LOCAL;
    else                return GRP_IN;
  endfunction

  // Unified physical index: globals occupy 0..7, windows follow
  function automatic int map_phys(input int lidx, input int cwp, input int nwin);
    if (group_of(lidx) == GRP_GLOBAL) return lidx;
    return GLOBALS + (((lidx - GLOBALS) + cwp * WIN_STRIDE) % (WIN_STRIDE * nwin));
  endfunction

  // Window reached by one call
  function automatic int next_win(input int cwp, input int nwin);
    return (cwp + 1) % nwin;
  endfunction

endpackage

// File: rtl/wrf_xlate.sv
module wrf_xlate #(
  parameter int NWIN = 8,
  parameter int CW   = 3,
  parameter int PW   = 8
) (
  input  logic [wrf_pkg::LIDX_W-1:0] lidx,
  input  logic [CW-1:0]              cwp,
  output logic [PW-1:0]              phys
);

  always_comb begin
    phys = PW'(wrf_pkg::map_phys(int'(lidx), int'(cwp), NWIN));
  end

endmodule

// File: rtl/wrf_store.sv
module wrf_store #(
  parameter int DW   = 32,
  parameter int NENT = 136,
  parameter int PW   = 8,
  parameter int NRD  = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [PW-1:0]           wr_phys,
  input  logic [DW-1:0]           wr_data,
  input  logic [NRD-1:0][PW-1:0]  rd_phys,
  output logic [NRD-1:0][DW-1:0]  rd_data
);

  logic [DW-1:0] mem [NENT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NENT; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[wr_phys] <= wr_data;
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    logic          fwd_hit;
    logic [DW-1:0] q;
    assign fwd_hit = wr_en && (wr_phys == rd_phys[p]);
    always_comb begin
      if (fwd_hit) q = wr_data;
      else         q = mem[rd_phys[p]];
    end
    assign rd_data[p] = q;
  end

  // R5: first cycle after reset, storage reads zero
  a_r5_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!rst_n) && !wr_en) |-> (rd_data[0] == '0));

  // R6: no write in flight, stable address -> stable data
  a_r6_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(wr_en) && !wr_en && $stable(rd_phys[0])) |-> $stable(rd_data[0]));

  // R7: forwarded value equals the value later read from storage
  a_r7_fwd_consistent: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_en && (wr_phys == rd_phys[0])) && !wr_en && $stable(rd_phys[0]))
      |-> (rd_data[0] == $past(rd_data[0])));

endmodule

// File: rtl/wreg_file.sv
module wreg_file #(
  parameter int NWINDOWS = 8,
  parameter int DW       = 32,
  localparam int CW      = (NWINDOWS > 1) ? $clog2(NWINDOWS) : 1,
  localparam int NENT    = wrf_pkg::GLOBALS + wrf_pkg::WIN_STRIDE * NWINDOWS,
  localparam int PW      = $clog2(NENT)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] win_ptr,
  input  logic [4:0]    rd_a_idx,
  output logic [DW-1:0] rd_a_data,
  input  logic [4:0]    rd_b_idx,
  output logic [DW-1:0] rd_b_data,
  input  logic          wr_en,
  input  logic [4:0]    wr_idx,
  input  logic [DW-1:0] wr_data
);

  localparam int NPORT = 3;

  logic [NPORT-1:0][4:0]    lidx_v;
  logic [NPORT-1:0][PW-1:0] phys_v;
  logic [PW-1:0]            phys_a, phys_b, phys_w;
  logic [1:0][DW-1:0]       rd_q;

  assign lidx_v = {wr_idx, rd_b_idx, rd_a_idx};

  for (genvar p = 0; p < NPORT; p++) begin : g_xl
    wrf_xlate #(.NWIN(NWINDOWS), .CW(CW), .PW(PW)) u_xl (
      .lidx (lidx_v[p]),
      .cwp  (win_ptr),
      .phys (phys_v[p])
    );
  end

  assign phys_a = phys_v[0];
  assign phys_b = phys_v[1];
  assign phys_w = phys_v[2];

  wrf_store #(.DW(DW), .NENT(NENT), .PW(PW), .NRD(2)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_phys (phys_w),
    .wr_data (wr_data),
    .rd_phys ({phys_b, phys_a}),
    .rd_data (rd_q)
  );

  assign rd_a_data = rd_q[0];
  assign rd_b_data = rd_q[1];

  // R1: a global index keeps its entry while the window moves
  a_r1_global_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_a_idx < 5'd8 && $stable(rd_a_idx)) |-> $stable(phys_a));

  // R2: windowed indices never land in the global bank
  a_r2_windowed_range: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_a_idx >= 5'd8) |-> (phys_a >= PW'(8) && int'(phys_a) < NENT));

  // R3: after one call, in k reappears as out k on the same entry
  a_r3_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    ((int'(win_ptr) == wrf_pkg::next_win(int'($past(win_ptr)), NWINDOWS)) &&
     ($past(rd_a_idx) >= 5'd24) && (rd_a_idx == $past(rd_a_idx) - 5'd16))
      |-> (phys_a == $past(phys_a)));

endmodule

// File: tb/wreg_file_test.sv
`timescale 1ns/1ps
module wreg_file_test;

  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [2:0]    win_ptr = '0;
  logic [4:0]    rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
  logic [DW-1:0] rd_a_data, rd_b_data, wr_data = '0;
  logic          wr_en = 1'b0;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  wreg_file #(.NWINDOWS(8), .DW(DW)) uut (
    .clk(clk), .rst_n(rst_n), .win_ptr(win_ptr),
    .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data)
  );

  // fields: [44:41] requirement, [40] 1=write, [39:37] ptr, [36:32] index, [31:0] value
  localparam int NV = 18;
  localparam logic [44:0] VEC [NV] = '{
    {4'd1, 1'b1, 3'd0, 5'd3,  32'h11},  // R1 write global 3
    {4'd1, 1'b0, 3'd5, 5'd3,  32'h11},  // R1 other window
    {4'd1, 1'b0, 3'd0, 5'd3,  32'h11},
    {4'd3, 1'b1, 3'd2, 5'd25, 32'h22},  // R3 in1 of w2
    {4'd3, 1'b0, 3'd3, 5'd9,  32'h22},  // R3 out1 of w3
    {4'd2, 1'b0, 3'd2, 5'd9,  32'h0},   // R2 out1 of w2 untouched
    {4'd3, 1'b1, 3'd7, 5'd24, 32'h33},  // R3 wrap: in0 of w7
    {4'd3, 1'b0, 3'd0, 5'd8,  32'h33},  // R3 out0 of w0
    {4'd4, 1'b1, 3'd4, 5'd18, 32'h44},  // R4 local2 of w4
    {4'd4, 1'b0, 3'd4, 5'd18, 32'h44},
    {4'd4, 1'b0, 3'd5, 5'd18, 32'h0},
    {4'd4, 1'b0, 3'd3, 5'd18, 32'h0},
    {4'd3, 1'b1, 3'd1, 5'd12, 32'h55},  // R3 out4 of w1
    {4'd3, 1'b0, 3'd0, 5'd28, 32'h55},  // R3 in4 of w0
    {4'd3, 1'b1, 3'd6, 5'd31, 32'h66},  // R3 in7 of w6
    {4'd3, 1'b0, 3'd7, 5'd15, 32'h66},  // R3 out7 of w7
    {4'd2, 1'b0, 3'd6, 5'd15, 32'h0},   // R2 out7 of w6 separate
    {4'd2, 1'b0, 3'd1, 5'd20, 32'h0}    // R2 local of w1 untouched
  };

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [2:0] p, input logic [4:0] i, input logic [DW-1:0] d);
    @(negedge clk);
    win_ptr = p; wr_idx = i; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_read(input string req, input logic [2:0] p, input logic [4:0] i,
                         input logic [DW-1:0] exp);
    @(negedge clk);
    win_ptr = p; rd_a_idx = i; rd_b_idx = i;
    #1;
    check({req, " port A"}, rd_a_data, exp);
    check({req, " port B"}, rd_b_data, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R5: reset state, several windows and groups
    do_read("R5", 3'd0, 5'd0,  32'h0);
    do_read("R5", 3'd3, 5'd17, 32'h0);
    do_read("R5", 3'd7, 5'd31, 32'h0);

    for (int k = 0; k < NV; k++) begin
      if (VEC[k][40])
        do_write(VEC[k][39:37], VEC[k][36:32], VEC[k][31:0]);
      else
        do_read($sformatf("R%0d vec%0d", VEC[k][44:41], k),
                VEC[k][39:37], VEC[k][36:32], VEC[k][31:0]);
    end

    // R8: different entries on the two ports in one cycle
    @(negedge clk);
    win_ptr = 3'd4; rd_a_idx = 5'd18; rd_b_idx = 5'd3;
    #1;
    check("R8 port A", rd_a_data, 32'h44);
    check("R8 port B", rd_b_data, 32'h11);

    // R6: disabled write to a global and to a local
    @(negedge clk);
    win_ptr = 3'd0; wr_idx = 5'd3; wr_data = 32'hdead; wr_en = 1'b0;
    @(negedge clk);
    win_ptr = 3'd4; wr_idx = 5'd18; wr_data = 32'hbeef;
    @(negedge clk);
    do_read("R6", 3'd0, 5'd3,  32'h11);
    do_read("R6", 3'd4, 5'd18, 32'h44);

    // R7: same-cycle forwarding, then the stored value
    @(negedge clk);
    win_ptr = 3'd2; wr_idx = 5'd20; wr_data = 32'h77; wr_en = 1'b1;
    rd_a_idx = 5'd20; rd_b_idx = 5'd3;
    #1;
    check("R7 forwarded", rd_a_data, 32'h77);
    check("R7 other port", rd_b_data, 32'h11);
    @(negedge clk);
    wr_en = 1'b0;
    #1;
    check("R7 stored", rd_a_data, 32'h77);

    // R5: reset again clears written entries
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    do_read("R5 after rerun", 3'd0, 5'd3,  32'h0);
    do_read("R5 after rerun", 3'd4, 5'd18, 32'h0);
    do_read("R5 after rerun", 3'd0, 5'd8,  32'h0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule